// File: doc/BRIEF.md
# LPC Bus Transaction Monitor

This block watches a Low Pin Count bus without driving it. On every rising edge of the bus clock it samples the active-low frame strobe and the 4-bit LAD nibble. It then follows each transaction through its phases: start, cycle type, address, first turnaround, sync (with wait states), data and second turnaround. When a cycle completes, the block emits a record with the cycle type, the address, the data byte and the last sync code seen, and it marks that record with a single-cycle valid pulse.

Beside the record, the monitor raises protocol warnings. These cover a start nibble that changes while the frame strobe is held low, an illegal cycle-type code, a turnaround nibble other than all-ones, and a reserved sync code. Single-byte I/O cycles and memory cycles are decoded. Other cycle kinds are recognised and then dropped. A host-side debug or compliance environment uses the records and the warning pulses.

Top module: `lpc_txn_monitor`

## Requirements
- R1: A cycle begins when `frame_ni` is sampled low. While it stays low, the nibble sampled on each clock replaces the stored start code, so the start code that counts is the one on the last low clock. Only start code 0000 (target cycle) leads to a decoded cycle. Any other start code returns the monitor to idle on the first high clock, and no record is produced.
- R2: If `frame_ni` is low on two consecutive clocks and the nibble differs between them, `warn_o[0]` pulses for one cycle in the clock after the second sample.
- R3: The nibble sampled on the first clock with `frame_ni` high is the cycle type. Codes 0000 and 0010 (I/O) and codes 0100 and 0110 (memory) proceed to the address phase. Every other code returns the monitor to idle with no record. `warn_o[1]` pulses when the code is not one of 0000, 0010, 0100, 0110, 1000 or 1010.
- R4: An I/O cycle takes IO_NIBS address nibbles (default 4) and a memory cycle takes MEM_NIBS (default 8), most significant nibble first. An I/O address is zero-extended in `rec_addr_o`.
- R5: Each turnaround phase takes TAR_CLKS clocks (default 2). `warn_o[2]` pulses in the clock after any turnaround nibble that is not 1111.
- R6: In the sync phase, codes 0101 (short wait) and 0110 (long wait) keep the monitor in sync. Codes 0000 (ready) and 1001 (ready-more) move it to data. Any code other than 0000, 0101, 0110, 1001 or 1010 keeps it in sync and pulses `warn_o[3]`. `rec_sync_o` reports the last sync code.
- R7: Sync code 1010 ends the cycle at once. The monitor emits a record with `rec_err_o`=1, `rec_sync_o`=1010 and `rec_data_o`=0, and skips the data and second turnaround phases.
- R8: The data byte takes DATA_NIBS clocks (default 2), least significant nibble first.
- R9: `rec_valid_o` is high for exactly one cycle, starting in the clock after the last nibble of a cycle is sampled. All record fields hold their values until the next record.
- R10: `frame_ni` sampled low in any phase abandons the cycle in progress without a record and restarts at the start phase.
- R11: With `rst_ni` low, the monitor returns to idle and all outputs and counters clear to zero. A cycle cut by reset produces no record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock, sampled on rising edges |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_ni | input | 1 | Active-low frame strobe from the bus |
| lad_i | input | 4 | Multiplexed address/control/data nibble |
| rec_valid_o | output | 1 | One-cycle pulse marking a new record |
| rec_err_o | output | 1 | Record ended on an error sync |
| rec_ctype_o | output | 4 | Cycle-type code of the record |
| rec_addr_o | output | MEM_NIBS*4 (32) | Captured address, I/O zero-extended |
| rec_data_o | output | DATA_NIBS*4 (8) | Captured data byte |
| rec_sync_o | output | 4 | Last sync code of the cycle |
| warn_o | output | 4 | Warning pulses: [0] start change, [1] bad type, [2] turnaround, [3] reserved sync |

## Verification
The assertions assume that `frame_ni` and `lad_i` change only away from the rising clock edge. They also assume that every cycle spans more than one clock from frame to record, which is what lets a record pulse be followed by a quiet cycle. The stimulus drives both inputs on the falling edge only, and it always presents a complete field sequence or a deliberate frame restart. The bench never releases the frame in a way that would make two records adjacent, so it stays inside these assumptions.

// File: rtl/lpc_mon_pkg.sv
package lpc_mon_pkg;

   localparam int NIB_W  = 4;
   localparam int WARN_N = 4;
   localparam int W_CHG  = 0;
   localparam int W_CT   = 1;
   localparam int W_TAR  = 2;
   localparam int W_SYNC = 3;

   typedef enum logic [2:0] {
      PH_IDLE, PH_START, PH_ADDR, PH_TAR1, PH_SYNC, PH_DATA, PH_TAR2
   } phase_e;

   typedef enum logic [1:0] {SK_GO, SK_WAIT, SK_FAIL, SK_RSVD} sync_kind_e;

   localparam logic [NIB_W-1:0] START_TGT = 4'b0000;
   localparam logic [NIB_W-1:0] TAR_IDLE  = 4'b1111;
   localparam logic [NIB_W-1:0] SY_READY  = 4'b0000;
   localparam logic [NIB_W-1:0] SY_SHORT  = 4'b0101;
   localparam logic [NIB_W-1:0] SY_LONG   = 4'b0110;
   localparam logic [NIB_W-1:0] SY_MORE   = 4'b1001;
   localparam logic [NIB_W-1:0] SY_ERR    = 4'b1010;

   function automatic logic ct_is_io(input logic [NIB_W-1:0] c);
      return (c[3:2] == 2'b00) && !c[0];
   endfunction

   function automatic logic ct_is_mem(input logic [NIB_W-1:0] c);
      return (c[3:2] == 2'b01) && !c[0];
   endfunction

   function automatic logic ct_legal(input logic [NIB_W-1:0] c);
      return !c[0] && (c[3:2] != 2'b11);
   endfunction

   function automatic sync_kind_e sync_kind(input logic [NIB_W-1:0] c);
      if (c == SY_READY || c == SY_MORE)     return SK_GO;
      else if (c == SY_SHORT || c == SY_LONG) return SK_WAIT;
      else if (c == SY_ERR)                   return SK_FAIL;
      else                                    return SK_RSVD;
   endfunction

endpackage

// File: rtl/lpc_mon_seq.sv
module lpc_mon_seq
   import lpc_mon_pkg::*;
#(
   parameter int IO_NIBS   = 4,
   parameter int MEM_NIBS  = 8,
   parameter int TAR_CLKS  = 2,
   parameter int DATA_NIBS = 2,
   parameter bit TAR_CHECK = 1'b1,
   parameter int CNT_W     = $clog2(MEM_NIBS)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              frame_ni,
   input  logic [NIB_W-1:0]  lad_i,
   output logic              ct_ld_o,
   output logic              addr_sh_o,
   output logic              data_ld_o,
   output logic [CNT_W-1:0]  data_idx_o,
   output logic              sync_ld_o,
   output logic              done_o,
   output logic              fail_o,
   output logic [WARN_N-1:0] warn_o
);

   localparam logic [CNT_W-1:0] LAST_IO   = CNT_W'(IO_NIBS - 1);
   localparam logic [CNT_W-1:0] LAST_MEM  = CNT_W'(MEM_NIBS - 1);
   localparam logic [CNT_W-1:0] LAST_TAR  = CNT_W'(TAR_CLKS - 1);
   localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_NIBS - 1);

   if (IO_NIBS < 1 || MEM_NIBS <= IO_NIBS) begin : g_bad_addr
      $error("lpc_mon_seq: need 1 <= IO_NIBS < MEM_NIBS");
   end
   if (TAR_CLKS < 1 || TAR_CLKS > MEM_NIBS) begin : g_bad_tar
      $error("lpc_mon_seq: TAR_CLKS out of range");
   end
   if (DATA_NIBS < 1 || DATA_NIBS > MEM_NIBS) begin : g_bad_data
      $error("lpc_mon_seq: DATA_NIBS out of range");
   end

   phase_e             ph_q, ph_d;
   logic [CNT_W-1:0]   cnt_q, cnt_d;
   logic [NIB_W-1:0]   start_q, start_d;
   logic               mem_q, mem_d;
   logic               w_chg, w_ct, w_tar_raw, w_tar, w_sy;
   logic [WARN_N-1:0]  warn_q;

   always_comb begin
      ph_d      = ph_q;
      cnt_d     = cnt_q;
      start_d   = start_q;
      mem_d     = mem_q;
      ct_ld_o   = 1'b0;
      addr_sh_o = 1'b0;
      data_ld_o = 1'b0;
      sync_ld_o = 1'b0;
      done_o    = 1'b0;
      fail_o    = 1'b0;
      w_chg     = 1'b0;
      w_ct      = 1'b0;
      w_tar_raw = 1'b0;
      w_sy      = 1'b0;
      if (!frame_ni) begin
         ph_d    = PH_START;
         start_d = lad_i;
         cnt_d   = '0;
         w_chg   = (ph_q == PH_START) && (lad_i != start_q);
      end else begin
         case (ph_q)
            PH_START: begin
               w_ct = !ct_legal(lad_i);
               if (start_q == START_TGT && (ct_is_io(lad_i) || ct_is_mem(lad_i))) begin
                  ph_d    = PH_ADDR;
                  ct_ld_o = 1'b1;
                  mem_d   = ct_is_mem(lad_i);
                  cnt_d   = '0;
               end else begin
                  ph_d = PH_IDLE;
               end
            end
            PH_ADDR: begin
               addr_sh_o = 1'b1;
               if (cnt_q == (mem_q ? LAST_MEM : LAST_IO)) begin
                  ph_d  = PH_TAR1;
                  cnt_d = '0;
               end else begin
                  cnt_d = cnt_q + CNT_W'(1);
               end
            end
            PH_TAR1, PH_TAR2: begin
               w_tar_raw = (lad_i != TAR_IDLE);
               if (cnt_q == LAST_TAR) begin
                  cnt_d = '0;
                  if (ph_q == PH_TAR1) begin
                     ph_d = PH_SYNC;
                  end else begin
                     ph_d   = PH_IDLE;
                     done_o = 1'b1;
                  end
               end else begin
                  cnt_d = cnt_q + CNT_W'(1);
               end
            end
            PH_SYNC: begin
               sync_ld_o = 1'b1;
               case (sync_kind(lad_i))
                  SK_GO: begin
                     ph_d  = PH_DATA;
                     cnt_d = '0;
                  end
                  SK_FAIL: begin
                     ph_d   = PH_IDLE;
                     fail_o = 1'b1;
                  end
                  SK_RSVD: w_sy = 1'b1;
                  default: ;
               endcase
            end
            PH_DATA: begin
               data_ld_o = 1'b1;
               if (cnt_q == LAST_DATA) begin
                  ph_d  = PH_TAR2;
                  cnt_d = '0;
               end else begin
                  cnt_d = cnt_q + CNT_W'(1);
               end
            end
            default: ;
         endcase
      end
   end

   if (TAR_CHECK) begin : g_tar_chk
      assign w_tar = w_tar_raw;
   end else begin : g_tar_off
      assign w_tar = 1'b0;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ph_q    <= PH_IDLE;
         cnt_q   <= '0;
         start_q <= '0;
         mem_q   <= 1'b0;
         warn_q  <= '0;
      end else begin
         ph_q    <= ph_d;
         cnt_q   <= cnt_d;
         start_q <= start_d;
         mem_q   <= mem_d;
         warn_q  <= '0;
         warn_q[W_CHG]  <= w_chg;
         warn_q[W_CT]   <= w_ct;
         warn_q[W_TAR]  <= w_tar;
         warn_q[W_SYNC] <= w_sy;
      end
   end

   assign data_idx_o = cnt_q;
   assign warn_o     = warn_q;

endmodule

// File: rtl/lpc_mon_rec.sv
module lpc_mon_rec
   import lpc_mon_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int DATA_NIBS = 2,
   parameter int CNT_W     = 3,
   parameter int DATA_W    = DATA_NIBS * NIB_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [NIB_W-1:0]  lad_i,
   input  logic              ct_ld_i,
   input  logic              addr_sh_i,
   input  logic              data_ld_i,
   input  logic [CNT_W-1:0]  data_idx_i,
   input  logic              sync_ld_i,
   input  logic              done_i,
   input  logic              fail_i,
   output logic              valid_o,
   output logic              err_o,
   output logic [NIB_W-1:0]  ctype_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] data_o,
   output logic [NIB_W-1:0]  sync_o
);

   logic [ADDR_W-1:0] addr_q;
   logic [NIB_W-1:0]  ct_q, sync_q;
   logic [DATA_W-1:0] data_w;

   for (genvar i = 0; i < DATA_NIBS; i++) begin : g_dnib
      logic [NIB_W-1:0] nib_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)
            nib_q <= '0;
         else if (data_ld_i && data_idx_i == CNT_W'(i))
            nib_q <= lad_i;
      end
      assign data_w[i*NIB_W +: NIB_W] = nib_q;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         addr_q  <= '0;
         ct_q    <= '0;
         sync_q  <= '0;
         valid_o <= 1'b0;
         err_o   <= 1'b0;
         ctype_o <= '0;
         addr_o  <= '0;
         data_o  <= '0;
         sync_o  <= '0;
      end else begin
         valid_o <= done_i | fail_i;
         if (ct_ld_i) begin
            ct_q   <= lad_i;
            addr_q <= '0;
         end else if (addr_sh_i) begin
            addr_q <= {addr_q[ADDR_W-NIB_W-1:0], lad_i};
         end
         if (sync_ld_i) sync_q <= lad_i;
         if (done_i) begin
            ctype_o <= ct_q;
            addr_o  <= addr_q;
            data_o  <= data_w;
            sync_o  <= sync_q;
            err_o   <= 1'b0;
         end else if (fail_i) begin
            ctype_o <= ct_q;
            addr_o  <= addr_q;
            data_o  <= '0;
            sync_o  <= lad_i;
            err_o   <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/lpc_txn_monitor.sv
module lpc_txn_monitor
   import lpc_mon_pkg::*;
#(
   parameter int IO_NIBS   = 4,
   parameter int MEM_NIBS  = 8,
   parameter int TAR_CLKS  = 2,
   parameter int DATA_NIBS = 2,
   parameter bit TAR_CHECK = 1'b1
) (
   input  logic                          clk_i,
   input  logic                          rst_ni,
   input  logic                          frame_ni,
   input  logic [NIB_W-1:0]              lad_i,
   output logic                          rec_valid_o,
   output logic                          rec_err_o,
   output logic [NIB_W-1:0]              rec_ctype_o,
   output logic [MEM_NIBS*NIB_W-1:0]     rec_addr_o,
   output logic [DATA_NIBS*NIB_W-1:0]    rec_data_o,
   output logic [NIB_W-1:0]              rec_sync_o,
   output logic [WARN_N-1:0]             warn_o
);

   localparam int ADDR_W = MEM_NIBS * NIB_W;
   localparam int CNT_W  = $clog2(MEM_NIBS);

   logic             ct_ld, addr_sh, data_ld, sync_ld, done, fail;
   logic [CNT_W-1:0] data_idx;

   lpc_mon_seq #(
      .IO_NIBS   (IO_NIBS),
      .MEM_NIBS  (MEM_NIBS),
      .TAR_CLKS  (TAR_CLKS),
      .DATA_NIBS (DATA_NIBS),
      .TAR_CHECK (TAR_CHECK),
      .CNT_W     (CNT_W)
   ) u_seq (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .frame_ni   (frame_ni),
      .lad_i      (lad_i),
      .ct_ld_o    (ct_ld),
      .addr_sh_o  (addr_sh),
      .data_ld_o  (data_ld),
      .data_idx_o (data_idx),
      .sync_ld_o  (sync_ld),
      .done_o     (done),
      .fail_o     (fail),
      .warn_o     (warn_o)
   );

   lpc_mon_rec #(
      .ADDR_W    (ADDR_W),
      .DATA_NIBS (DATA_NIBS),
      .CNT_W     (CNT_W)
   ) u_rec (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .lad_i      (lad_i),
      .ct_ld_i    (ct_ld),
      .addr_sh_i  (addr_sh),
      .data_ld_i  (data_ld),
      .data_idx_i (data_idx),
      .sync_ld_i  (sync_ld),
      .done_i     (done),
      .fail_i     (fail),
      .valid_o    (rec_valid_o),
      .err_o      (rec_err_o),
      .ctype_o    (rec_ctype_o),
      .addr_o     (rec_addr_o),
      .data_o     (rec_data_o),
      .sync_o     (rec_sync_o)
   );

endmodule

// File: rtl/lpc_mon_chk.sv
module lpc_mon_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 8
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              frame_ni,
   input logic [3:0]        lad_i,
   input logic              rec_valid_o,
   input logic              rec_err_o,
   input logic [3:0]        rec_ctype_o,
   input logic [ADDR_W-1:0] rec_addr_o,
   input logic [DATA_W-1:0] rec_data_o,
   input logic [3:0]        rec_sync_o,
   input logic [3:0]        warn_o
);

   // R10
   restart_no_rec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !frame_ni |=> !rec_valid_o);

   // R9
   single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rec_valid_o |=> !rec_valid_o);

   // R9
   record_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rec_valid_o |-> ($stable(rec_addr_o) && $stable(rec_data_o) &&
                        $stable(rec_sync_o) && $stable(rec_ctype_o) && $stable(rec_err_o)));

   // R7
   err_record_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rec_valid_o && rec_err_o) |-> ($past(lad_i) == 4'b1010 && rec_data_o == '0 &&
                                      rec_sync_o == 4'b1010));

   // R5
   tar_warn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      warn_o[2] |-> ($past(lad_i) != 4'b1111));

   // R2
   start_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      warn_o[0] |-> ($past(frame_ni) == 1'b0));

endmodule

bind lpc_txn_monitor lpc_mon_chk #(
   .ADDR_W (MEM_NIBS * 4),
   .DATA_W (DATA_NIBS * 4)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .frame_ni    (frame_ni),
   .lad_i       (lad_i),
   .rec_valid_o (rec_valid_o),
   .rec_err_o   (rec_err_o),
   .rec_ctype_o (rec_ctype_o),
   .rec_addr_o  (rec_addr_o),
   .rec_data_o  (rec_data_o),
   .rec_sync_o  (rec_sync_o),
   .warn_o      (warn_o)
);

// File: tb/sim_lpc_txn_monitor.sv
module sim_lpc_txn_monitor;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_n = 1'b1;
   logic [3:0]  lad = 4'hF;
   logic        rec_valid, rec_err;
   logic [3:0]  rec_ctype, rec_sync, warn;
   logic [31:0] rec_addr;
   logic [7:0]  rec_data;

   int checks = 0, failures = 0;
   int n_rec = 0;
   logic [31:0] r_addr = '0;
   logic [7:0]  r_data = '0;
   logic [3:0]  r_sync = '0, r_ct = '0, w_acc = '0;
   logic        r_err = 1'b0;
   bit          finished = 0;

   always #4 clk = ~clk;

   lpc_txn_monitor u0 (
      .clk_i(clk), .rst_ni(rst_n), .frame_ni(frame_n), .lad_i(lad),
      .rec_valid_o(rec_valid), .rec_err_o(rec_err), .rec_ctype_o(rec_ctype),
      .rec_addr_o(rec_addr), .rec_data_o(rec_data), .rec_sync_o(rec_sync),
      .warn_o(warn)
   );

   always @(negedge clk) begin
      if (rec_valid) begin
         n_rec  = n_rec + 1;
         r_addr = rec_addr; r_data = rec_data; r_sync = rec_sync;
         r_ct   = rec_ctype; r_err = rec_err;
      end
      w_acc = w_acc | warn;
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic step(input logic f, input logic [3:0] n);
      @(negedge clk);
      frame_n = f;
      lad = n;
   endtask

   task automatic clr();
      #2;
      n_rec = 0;
      w_acc = '0;
   endtask

   function automatic bit b_io(input logic [3:0] c);  return c == 4'h0 || c == 4'h2; endfunction
   function automatic bit b_mem(input logic [3:0] c); return c == 4'h4 || c == 4'h6; endfunction
   function automatic bit b_legal(input logic [3:0] c);
      return c inside {4'h0, 4'h2, 4'h4, 4'h6, 4'h8, 4'hA};
   endfunction
   function automatic bit b_sync_rsvd(input logic [3:0] c);
      return !(c inside {4'h0, 4'h5, 4'h6, 4'h9, 4'hA});
   endfunction

   // body after a one-clock start; ends after the record slot
   task automatic body(input logic [3:0] ct, input logic [31:0] a, input logic [7:0] d,
                       input int nwait, input logic [3:0] wcode, input logic [3:0] fin,
                       input logic [3:0] tarv, input bit exp_rec);
      int nn;
      nn = b_io(ct) ? 4 : 8;
      step(1'b1, ct);
      for (int i = 0; i < nn; i++) step(1'b1, a[(nn-1-i)*4 +: 4]);
      step(1'b1, tarv); step(1'b1, tarv);
      for (int i = 0; i < nwait; i++) step(1'b1, wcode);
      step(1'b1, fin);
      if (fin != 4'hA) begin
         step(1'b1, d[3:0]); step(1'b1, d[7:4]);
         step(1'b1, 4'hF); step(1'b1, 4'hF);
      end
      @(negedge clk);
      chk(rec_valid == exp_rec, "R9 latency", {31'b0, rec_valid}, {31'b0, exp_rec});
      @(negedge clk);
      chk(rec_valid == 1'b0, "R9 one-cycle pulse", {31'b0, rec_valid}, 32'h0);
      #2;
   endtask

   function automatic logic [31:0] exp_addr(input logic [3:0] ct, input logic [31:0] a);
      return b_io(ct) ? {16'h0, a[15:0]} : a;
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      chk(rec_valid == 0 && rec_addr == 0 && warn == 0, "R11 reset state", rec_addr, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rec_valid == 0 && rec_data == 0, "R11 after release", {24'h0, rec_data}, 32'h0);
      clr();

      // R3 / R4: sweep every cycle-type code
      for (int c = 0; c < 16; c++) begin
         logic [3:0] ct;
         ct = 4'(c);
         step(1'b0, 4'h0);
         if (b_io(ct) || b_mem(ct)) begin
            body(ct, 32'hA5C3_1E70, 8'h3C, 0, 4'h5, 4'h0, 4'hF, 1'b1);
            chk(n_rec == 1, "R3 record count", n_rec, 1);
            chk(r_addr == exp_addr(ct, 32'hA5C3_1E70), "R4 address", r_addr, exp_addr(ct, 32'hA5C3_1E70));
            chk(r_ct == ct, "R3 ctype", {28'h0, r_ct}, {28'h0, ct});
         end else begin
            step(1'b1, ct); step(1'b1, 4'hF); step(1'b1, 4'hF); #2;
            chk(n_rec == 0, "R3 dropped type", n_rec, 0);
         end
         chk(w_acc[1] == !b_legal(ct), "R3 type warning", {31'h0, w_acc[1]}, {31'h0, !b_legal(ct)});
         clr();
      end

      // R8 / R4: data sweep on I/O writes
      for (int v = 0; v < 256; v++) begin
         logic [31:0] a;
         a = 32'(v * 257);
         step(1'b0, 4'h0);
         body(4'h2, a, 8'(v), 0, 4'h5, 4'h0, 4'hF, 1'b1);
         chk(r_data == 8'(v), "R8 data byte", {24'h0, r_data}, 32'(v));
         chk(r_addr == {16'h0, a[15:0]}, "R4 io address", r_addr, {16'h0, a[15:0]});
         chk(w_acc == 0 && rec_err == 0, "R8 clean cycle", {28'h0, w_acc}, 32'h0);
         clr();
      end

      // R4: memory addresses
      foreach (u0.rec_addr_o[i]) begin
         logic [31:0] a;
         a = 32'h1 << i;
         step(1'b0, 4'h0);
         body(4'h4, a ^ 32'h0123_4567, 8'h81, 0, 4'h5, 4'h0, 4'hF, 1'b1);
         chk(r_addr == (a ^ 32'h0123_4567), "R4 memory address", r_addr, a ^ 32'h0123_4567);
         clr();
      end

      // R6: wait states then ready / ready-more
      for (int w = 0; w < 8; w++) begin
         logic [3:0] fin, wc;
         fin = w[0] ? 4'h9 : 4'h0;
         wc  = w[1] ? 4'h6 : 4'h5;
         step(1'b0, 4'h0);
         body(4'h6, 32'hDEAD_BEEF, 8'(w + 16), w / 2, wc, fin, 4'hF, 1'b1);
         chk(n_rec == 1 && r_sync == fin, "R6 final sync", {28'h0, r_sync}, {28'h0, fin});
         chk(r_data == 8'(w + 16), "R6 data after waits", {24'h0, r_data}, 32'(w + 16));
         chk(w_acc[3] == 0, "R6 no sync warning", {28'h0, w_acc}, 32'h0);
         clr();
      end

      // R6: each non-ready, non-error code as a single wait nibble
      for (int s = 0; s < 16; s++) begin
         logic [3:0] sc;
         sc = 4'(s);
         if (sc != 4'h0 && sc != 4'h9 && sc != 4'hA) begin
            step(1'b0, 4'h0);
            body(4'h0, 32'h0000_4321, 8'h5A, 1, sc, 4'h0, 4'hF, 1'b1);
            chk(w_acc[3] == b_sync_rsvd(sc), "R6 reserved sync warning", {31'h0, w_acc[3]}, {31'h0, b_sync_rsvd(sc)});
            chk(r_data == 8'h5A, "R6 stays in sync", {24'h0, r_data}, 32'h5A);
            clr();
         end
      end

      // R5: bad turnaround
      step(1'b0, 4'h0);
      body(4'h0, 32'h0000_1111, 8'h22, 0, 4'h5, 4'h0, 4'h7, 1'b1);
      chk(w_acc[2] == 1 && n_rec == 1, "R5 turnaround warning", {28'h0, w_acc}, 32'h4);
      chk(r_data == 8'h22, "R5 fixed length", {24'h0, r_data}, 32'h22);
      clr();

      // R7: error sync
      step(1'b0, 4'h0);
      body(4'h4, 32'h8000_0001, 8'h77, 2, 4'h6, 4'hA, 4'hF, 1'b1);
      chk(n_rec == 1 && r_err == 1, "R7 error flag", {31'h0, r_err}, 32'h1);
      chk(r_sync == 4'hA && r_data == 0, "R7 error record", {20'h0, r_sync, r_data}, 32'hA00);
      chk(r_addr == 32'h8000_0001, "R7 address kept", r_addr, 32'h8000_0001);
      clr();

      // R1 / R2: multi-clock frame
      step(1'b0, 4'h0); step(1'b0, 4'h0); step(1'b0, 4'h0);
      body(4'h0, 32'h0000_ABCD, 8'h10, 0, 4'h5, 4'h0, 4'hF, 1'b1);
      chk(n_rec == 1 && w_acc[0] == 0, "R1 held frame", {28'h0, w_acc}, 32'h0);
      clr();
      step(1'b0, 4'h5); step(1'b0, 4'h0);
      body(4'h0, 32'h0000_1234, 8'h11, 0, 4'h5, 4'h0, 4'hF, 1'b1);
      chk(n_rec == 1 && w_acc[0] == 1, "R2 last start counts", {28'h0, w_acc}, 32'h1);
      clr();
      step(1'b0, 4'h0); step(1'b0, 4'hF);
      body(4'h0, 32'h0000_1234, 8'h11, 0, 4'h5, 4'h0, 4'hF, 1'b0);
      chk(n_rec == 0 && w_acc[0] == 1, "R1 abort start", n_rec, 0);
      clr();
      for (int s = 1; s < 16; s++) begin
         step(1'b0, 4'(s));
         body(4'h2, 32'h0000_0F0F, 8'h33, 0, 4'h5, 4'h0, 4'hF, 1'b0);
         chk(n_rec == 0, "R1 non-target start", n_rec, 0);
         clr();
      end

      // R10: frame low mid-address restarts
      step(1'b0, 4'h0); step(1'b1, 4'h4);
      step(1'b1, 4'h9); step(1'b1, 4'h9); step(1'b1, 4'h9);
      step(1'b0, 4'h0);
      body(4'h2, 32'h0000_C0DE, 8'h44, 0, 4'h5, 4'h0, 4'hF, 1'b1);
      chk(n_rec == 1 && r_addr == 32'h0000_C0DE, "R10 restart", r_addr, 32'h0000_C0DE);
      chk(r_ct == 4'h2, "R10 restarted type", {28'h0, r_ct}, 32'h2);
      clr();

      // R11: reset in the middle of a cycle
      step(1'b0, 4'h0); step(1'b1, 4'h2); step(1'b1, 4'h1); step(1'b1, 4'h2);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      chk(rec_addr == 0 && rec_data == 0, "R11 cleared record", rec_addr, 32'h0);
      step(1'b1, 4'h3); step(1'b1, 4'h4); step(1'b1, 4'hF); step(1'b1, 4'hF);
      step(1'b1, 4'h0); step(1'b1, 4'h1); step(1'b1, 4'h2); step(1'b1, 4'hF);
      step(1'b1, 4'hF); step(1'b1, 4'hF); step(1'b1, 4'hF); #2;
      chk(n_rec == 0 && w_acc == 0, "R11 no record after reset", n_rec, 0);
      clr();

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule